// File: doc/BRIEF.md
# Two-by-Two Clock Crossbar with Glitch-Free Bank Gating

This block steers two incoming clocks onto two output banks, each bank carrying three identical outputs. A two-bit route select chooses one of four maps. Either input can feed both banks. The two inputs can go straight to the two banks. The two inputs can also go crossed, so that each input feeds the opposite bank. Every output is a true/complement pair.

Each bank has its own active-high stop input, which may be driven at any moment with no relation to any clock. The block brings that request into the domain of the clock that currently feeds the bank, through a two-flop synchronizer and one hold flop. It then updates the bank's gate only on a falling edge of that clock. An output therefore stops or restarts only while it is already low, and it never shows a shortened high or low pulse. Stop and restart latencies are fixed in periods of the bank's own clock.

Glitch-free behaviour while the route select itself changes is not covered. The select is expected to be static while the banks are in use, or changed only while both banks are stopped.

Top module: `clk_xbar_2x2`

## Requirements
- R1: With route_sel = 2'b00, every true output of bank A and bank B follows clk_src0.
- R2: With route_sel = 2'b01, every true output of both banks follows clk_src1.
- R3: With route_sel = 2'b10, bank A follows clk_src0 and bank B follows clk_src1.
- R4: With route_sel = 2'b11, bank A follows clk_src1 and bank B follows clk_src0.
- R5: Each complement output is always the inverse of its true output, and the three outputs of a bank are identical.
- R6: While a bank's stop input (bank_off bit 0 for bank A, bit 1 for bank B) has been 1 long enough to take effect, that bank's true outputs are held at 0 and its complement outputs at 1.
- R7: After bank_off rises, the bank's last output transition (its final falling edge) comes more than 2.5 and at most 3.5 periods of the bank's clock after the request.
- R8: After bank_off falls, the bank's first rising output edge comes more than 3 and at most 4 periods of the bank's clock after the request.
- R9: No runt pulse: every high pulse on an output lasts exactly half a period of its clock, and every low pulse lasts at least half a period.
- R10: Stopping one bank has no effect on the other bank, which keeps toggling.
- R11: While rst_n is 0, both banks are held stopped (true 0, complement 1). After release with bank_off = 0, both banks start toggling.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_src0 | input | 1 | Input clock 0 |
| clk_src1 | input | 1 | Input clock 1 |
| rst_n | input | 1 | Asynchronous active-low reset |
| route_sel | input | 2 | Route map select (00, 01, 10, 11 as in R1 to R4) |
| bank_off | input | 2 | Per-bank stop request, asynchronous; bit 0 bank A, bit 1 bank B |
| bank_a_p | output | 3 | Bank A true outputs |
| bank_a_n | output | 3 | Bank A complement outputs |
| bank_b_p | output | 3 | Bank B true outputs |
| bank_b_n | output | 3 | Bank B complement outputs |

## Verification
The bench drives the two input clocks at unrelated periods, so any swap in the route map shows up as a sample mismatch. It places stop and restart requests just after and just before a rising edge of the bank's clock, which drives the latency to both ends of its window. A synchronizer one stage too short or too long pushes the measured latency out of its window. A gate clocked on the rising edge produces a shortened high pulse, which the pulse-width monitor flags. Each request is repeated under every route map and for each bank, while the other bank is watched for edges, so a crossed stop line or a shared synchronizer is also caught.

// File: rtl/clk_xbar_pkg.sv
`timescale 1ns/1ps
package clk_xbar_pkg;

    localparam int unsigned NUM_BANKS = 2;

    typedef enum logic [1:0] {
        ROUTE_ALL0  = 2'b00,
        ROUTE_ALL1  = 2'b01,
        ROUTE_SPLIT = 2'b10,
        ROUTE_CROSS = 2'b11
    } route_mode_e;

    // Index of the source clock that feeds a given bank under a route map.
    function automatic logic route_src(input logic [1:0] sel, input int unsigned bank);
        logic src;
        unique case (route_mode_e'(sel))
            ROUTE_ALL0:  src = 1'b0;
            ROUTE_ALL1:  src = 1'b1;
            ROUTE_SPLIT: src = (bank == 0) ? 1'b0 : 1'b1;
            ROUTE_CROSS: src = (bank == 0) ? 1'b1 : 1'b0;
            default:     src = 1'b0;
        endcase
        return src;
    endfunction

endpackage

// File: rtl/clk_xbar_route.sv
`timescale 1ns/1ps
module clk_xbar_route
    import clk_xbar_pkg::*;
#(
    parameter int unsigned BANKS = NUM_BANKS
) (
    input  logic [1:0]       src_clk,
    input  logic [1:0]       route_sel,
    output logic [BANKS-1:0] bank_clk
);

    for (genvar b = 0; b < BANKS; b++) begin : g_bank_mux
        always_comb begin
            bank_clk[b] = src_clk[route_src(route_sel, b)];
        end
    end

endmodule

// File: rtl/clk_xbar_sync.sv
`timescale 1ns/1ps
module clk_xbar_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_in,
    output logic sync_out
);

    typedef struct packed {
        logic [STAGES-1:0] chain;
    } sync_state_t;

    sync_state_t st_d, st_q;

    always_comb begin
        st_d       = st_q;
        st_d.chain = {st_q.chain[STAGES-2:0], async_in};
    end

    // Reset to the stopped state so a bank never starts mid-pulse.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '{chain: '1};
        else        st_q <= st_d;
    end

    assign sync_out = st_q.chain[STAGES-1];

endmodule

// File: rtl/clk_xbar_bank_gate.sv
`timescale 1ns/1ps
module clk_xbar_bank_gate #(
    parameter int unsigned WIDTH       = 3,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic             bank_clk,
    input  logic             rst_n,
    input  logic             bank_off,
    output logic [WIDTH-1:0] out_p,
    output logic [WIDTH-1:0] out_n,
    output logic             gate_off
);

    typedef struct packed {
        logic off_hold;
    } rise_state_t;

    typedef struct packed {
        logic gate;
    } fall_state_t;

    logic        off_sync;
    rise_state_t rise_d, rise_q;
    fall_state_t fall_d, fall_q;

    clk_xbar_sync #(.STAGES(SYNC_STAGES)) sync_i (
        .clk      (bank_clk),
        .rst_n    (rst_n),
        .async_in (bank_off),
        .sync_out (off_sync)
    );

    // Hold stage in the rising-edge domain.
    always_comb begin
        rise_d          = rise_q;
        rise_d.off_hold = off_sync;
    end

    always_ff @(posedge bank_clk or negedge rst_n) begin
        if (!rst_n) rise_q <= '{off_hold: 1'b1};
        else        rise_q <= rise_d;
    end

    // Gate updates only as the clock falls, so the output is already low.
    always_comb begin
        fall_d      = fall_q;
        fall_d.gate = rise_q.off_hold;
    end

    always_ff @(negedge bank_clk or negedge rst_n) begin
        if (!rst_n) fall_q <= '{gate: 1'b1};
        else        fall_q <= fall_d;
    end

    assign gate_off = fall_q.gate;

    for (genvar i = 0; i < WIDTH; i++) begin : g_fanout
        assign out_p[i] = bank_clk & ~fall_q.gate;
        assign out_n[i] = ~bank_clk | fall_q.gate;
    end

endmodule

// File: rtl/clk_xbar_2x2.sv
`timescale 1ns/1ps
module clk_xbar_2x2
    import clk_xbar_pkg::*;
#(
    parameter int unsigned BANK_WIDTH  = 3,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic                  clk_src0,
    input  logic                  clk_src1,
    input  logic                  rst_n,
    input  logic [1:0]            route_sel,
    input  logic [NUM_BANKS-1:0]  bank_off,
    output logic [BANK_WIDTH-1:0] bank_a_p,
    output logic [BANK_WIDTH-1:0] bank_a_n,
    output logic [BANK_WIDTH-1:0] bank_b_p,
    output logic [BANK_WIDTH-1:0] bank_b_n
);

    logic [NUM_BANKS-1:0]  bank_clk;
    logic [NUM_BANKS-1:0]  gate_off;
    logic [BANK_WIDTH-1:0] out_p [NUM_BANKS];
    logic [BANK_WIDTH-1:0] out_n [NUM_BANKS];

    clk_xbar_route #(.BANKS(NUM_BANKS)) route_i (
        .src_clk   ({clk_src1, clk_src0}),
        .route_sel (route_sel),
        .bank_clk  (bank_clk)
    );

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        clk_xbar_bank_gate #(
            .WIDTH       (BANK_WIDTH),
            .SYNC_STAGES (SYNC_STAGES)
        ) gate_i (
            .bank_clk (bank_clk[b]),
            .rst_n    (rst_n),
            .bank_off (bank_off[b]),
            .out_p    (out_p[b]),
            .out_n    (out_n[b]),
            .gate_off (gate_off[b])
        );
    end

    assign bank_a_p = out_p[0];
    assign bank_a_n = out_n[0];
    assign bank_b_p = out_p[1];
    assign bank_b_n = out_n[1];

endmodule

// File: rtl/clk_xbar_chk.sv
`timescale 1ns/1ps
module clk_xbar_chk #(
    parameter int unsigned BANKS = 2,
    parameter int unsigned WIDTH = 3
) (
    input logic             rst_n,
    input logic [BANKS-1:0] bank_clk,
    input logic [BANKS-1:0] gate_off,
    input logic [WIDTH-1:0] a_p,
    input logic [WIDTH-1:0] a_n,
    input logic [WIDTH-1:0] b_p,
    input logic [WIDTH-1:0] b_n
);

    logic [WIDTH-1:0] p_arr [BANKS];
    logic [WIDTH-1:0] n_arr [BANKS];

    assign p_arr[0] = a_p;
    assign n_arr[0] = a_n;
    assign p_arr[1] = b_p;
    assign n_arr[1] = b_n;

    for (genvar b = 0; b < BANKS; b++) begin : g_chk
        logic gate_at_rise;

        always_ff @(posedge bank_clk[b] or negedge rst_n) begin
            if (!rst_n) gate_at_rise <= 1'b1;
            else        gate_at_rise <= gate_off[b];
        end

        // R5: complement tracks true output
        p_pair_r5: assert property (@(negedge bank_clk[b]) disable iff (!rst_n)
            n_arr[b] == ~p_arr[b]);

        // R6: a stopped bank kept its true outputs low through the high phase
        p_off_low_r6: assert property (@(negedge bank_clk[b]) disable iff (!rst_n)
            gate_off[b] |-> (p_arr[b] == '0 && n_arr[b] == '1));

        // R5: an open bank passed the whole high phase to every output
        p_on_follow_r5: assert property (@(negedge bank_clk[b]) disable iff (!rst_n)
            !gate_off[b] |-> (p_arr[b] == '1));

        // R9: the gate never moves while the clock is high
        p_gate_steady_r9: assert property (@(negedge bank_clk[b]) disable iff (!rst_n)
            gate_off[b] == gate_at_rise);
    end

endmodule

bind clk_xbar_2x2 clk_xbar_chk #(.BANKS(2), .WIDTH(BANK_WIDTH)) chk_i (
    .rst_n    (rst_n),
    .bank_clk (bank_clk),
    .gate_off (gate_off),
    .a_p      (bank_a_p),
    .a_n      (bank_a_n),
    .b_p      (bank_b_p),
    .b_n      (bank_b_n)
);

// File: tb/clk_xbar_2x2_tb.sv
`timescale 1ns/1ps
module clk_xbar_2x2_tb_top;

    localparam real CLK_PERIOD  = 10.0;
    localparam real CLK1_PERIOD = 14.0;
    localparam int  W           = 3;

    logic         clk_src0 = 1'b0;
    logic         clk_src1 = 1'b0;
    logic         rst_n;
    logic [1:0]   route_sel;
    logic [1:0]   bank_off;
    logic [W-1:0] bank_a_p, bank_a_n, bank_b_p, bank_b_n;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 0;

    always #(CLK_PERIOD / 2.0)  clk_src0 = ~clk_src0;
    always #(CLK1_PERIOD / 2.0) clk_src1 = ~clk_src1;

    clk_xbar_2x2 dut_i (
        .clk_src0  (clk_src0),
        .clk_src1  (clk_src1),
        .rst_n     (rst_n),
        .route_sel (route_sel),
        .bank_off  (bank_off),
        .bank_a_p  (bank_a_p),
        .bank_a_n  (bank_a_n),
        .bank_b_p  (bank_b_p),
        .bank_b_n  (bank_b_n)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input real act, input real exp_v);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0.2f expected %0.2f", req, what, act, exp_v);
        end
    endtask

    // Expected source index per bank, from R1..R4.
    function automatic int exp_src(input logic [1:0] sel, input int b);
        case (sel)
            2'b00:   return 0;
            2'b01:   return 1;
            2'b10:   return (b == 0) ? 0 : 1;
            default: return (b == 0) ? 1 : 0;
        endcase
    endfunction

    function automatic real period_of(input int src);
        return (src == 0) ? CLK_PERIOD : CLK1_PERIOD;
    endfunction

    // Edge monitor on output 0 of each bank (R9, R10, R7, R8).
    realtime last_t [2];
    realtime rise_t [2];
    bit      have   [2];
    bit      arm    [2];
    int      edges  [2];
    int      runt_err = 0;
    bit      mon_on   = 0;

    task automatic on_edge(input int b, input logic v);
        realtime now;
        real     half;
        now  = $realtime;
        half = period_of(exp_src(route_sel, b)) / 2.0;
        if (mon_on && have[b]) begin
            if (v == 1'b0 && (now - last_t[b]) != half) runt_err++;
            if (v == 1'b1 && (now - last_t[b]) <  half) runt_err++;
        end
        if (v == 1'b1 && arm[b]) begin
            rise_t[b] = now;
            arm[b]    = 0;
        end
        edges[b]++;
        last_t[b] = now;
        have[b]   = 1;
    endtask

    always @(bank_a_p[0]) on_edge(0, bank_a_p[0]);
    always @(bank_b_p[0]) on_edge(1, bank_b_p[0]);

    function automatic logic [W-1:0] bank_p(input int b);
        return (b == 0) ? bank_a_p : bank_b_p;
    endfunction

    function automatic logic [W-1:0] bank_n(input int b);
        return (b == 0) ? bank_a_n : bank_b_n;
    endfunction

    task automatic wait_src_rise(input int src);
        if (src == 0) @(posedge clk_src0);
        else          @(posedge clk_src1);
    endtask

    task automatic route_check(input logic [1:0] sel, input string req);
        int mism, pair_bad;
        mon_on    = 0;
        route_sel = sel;
        bank_off  = 2'b00;
        #(8.0 * CLK1_PERIOD);
        have[0] = 0;
        have[1] = 0;
        mon_on  = 1;
        mism     = 0;
        pair_bad = 0;
        @(posedge clk_src0);
        #0.5;
        for (int k = 0; k < 120; k++) begin
            for (int b = 0; b < 2; b++) begin
                logic e;
                e = (exp_src(sel, b) == 0) ? clk_src0 : clk_src1;
                if (bank_p(b) != {W{e}}) mism++;
                if (bank_n(b) != ~bank_p(b)) pair_bad++;
            end
            #1.0;
        end
        check(mism == 0, req, "outputs follow routed source", mism, 0);
        check(pair_bad == 0, "R5", "complement pairs", pair_bad, 0);
    endtask

    task automatic latency_test(input int b, input bit late);
        int      src;
        real     t, off;
        realtime treq;
        int      other0;
        src = exp_src(route_sel, b);
        t   = period_of(src);
        off = late ? (t - 0.3) : 0.3;

        // stop request
        wait_src_rise(src);
        #(off);
        treq   = $realtime;
        other0 = edges[1 - b];
        bank_off[b] = 1'b1;
        #(5.0 * t);
        check((last_t[b] - treq) > 2.5 * t && (last_t[b] - treq) <= 3.5 * t,
              "R7", "stop latency (ns)", last_t[b] - treq, 3.0 * t);
        check(bank_p(b) == '0 && bank_n(b) == '1, "R6", "stopped levels",
              bank_p(b), 0);
        #(0.37 * t);
        check(bank_p(b) == '0 && bank_n(b) == '1, "R6", "stopped levels later",
              bank_p(b), 0);
        check(edges[1 - b] > other0 + 4, "R10", "other bank edges",
              edges[1 - b] - other0, 5);

        // restart request
        wait_src_rise(src);
        #(off);
        treq   = $realtime;
        arm[b] = 1;
        bank_off[b] = 1'b0;
        #(5.0 * t);
        check(!arm[b] && (rise_t[b] - treq) > 3.0 * t && (rise_t[b] - treq) <= 4.0 * t,
              "R8", "restart latency (ns)", rise_t[b] - treq, 3.5 * t);
    endtask

    initial begin
        int e0, e1;
        rst_n     = 1'b0;
        route_sel = 2'b00;
        bank_off  = 2'b00;
        #23.3;
        check(bank_a_p == '0 && bank_a_n == '1 && bank_b_p == '0 && bank_b_n == '1,
              "R11", "levels in reset", bank_a_p, 0);
        #11.9;
        check(bank_a_p == '0 && bank_b_p == '0, "R11", "levels in reset later",
              bank_b_p, 0);
        #5.1;
        rst_n = 1'b1;
        e0 = edges[0];
        e1 = edges[1];
        #(10.0 * CLK_PERIOD);
        check(edges[0] > e0 && edges[1] > e1, "R11", "toggling after reset",
              edges[0] - e0, 1);

        route_check(2'b00, "R1");
        for (int b = 0; b < 2; b++) begin
            latency_test(b, 1'b0);
            latency_test(b, 1'b1);
        end
        route_check(2'b01, "R2");
        for (int b = 0; b < 2; b++) begin
            latency_test(b, 1'b0);
            latency_test(b, 1'b1);
        end
        route_check(2'b10, "R3");
        for (int b = 0; b < 2; b++) begin
            latency_test(b, 1'b0);
            latency_test(b, 1'b1);
        end
        route_check(2'b11, "R4");
        for (int b = 0; b < 2; b++) begin
            latency_test(b, 1'b0);
            latency_test(b, 1'b1);
        end

        check(runt_err == 0, "R9", "pulse widths", runt_err, 0);
        finished = 1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        #(200000.0 * CLK_PERIOD);
        if (!finished) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

endmodule